// File: doc/BRIEF.md
# Host Bus Port with Two-Pass Data Memory Reads

This block connects a host processor to the storage of a switching device. The host uses an asynchronous, non-multiplexed bus: one chip select, one data strobe, a read/write line, a 14-bit address, 16-bit data and an active-low acknowledge. The block decodes the address into one of five regions. Control registers and connection memory can be read and written. Error count registers and data memory can only be read. Unmapped register slots read as zero.

Data memory is written by the switching core through a separate port. The host cannot read it directly: each host read of data memory returns the value held in a one-word read latch, then loads that latch from the addressed word. To get the true content of a word, the host reads the same address twice in a row and discards the first result. A host write to a read-only region completes the handshake normally and changes nothing.

Top module: `host_microport`

## Requirements
- R1: The acknowledge `ack_no_o` (active low) goes low at the second rising clock edge after an edge that sampled both `cs_ni` and `ds_ni` low. A strobe without chip select produces no acknowledge and no access.
- R2: When `ds_ni` goes high, `ack_no_o` goes high in the same cycle and stays high until a new strobe starts.
- R3: Control registers occupy `addr_i[13]=0`, `addr_i[12]=0`, with index `addr_i[3:0]` equal to 0..3. They can be written and read back (`rw_i`=1 read, 0 write).
- R4: The 64-word connection memory occupies `addr_i[13]=0`, `addr_i[12]=1`, with the word index in `addr_i[5:0]`. It can be written and read back.
- R5: Data memory occupies `addr_i[13]=1`, with the word index in `addr_i[5:0]`. A read returns the read latch's current value, then loads the latch with the addressed word. Two reads in a row at the same address therefore return the true word on the second read.
- R6: A host write to data memory is acknowledged but changes neither the memory nor the read latch.
- R7: Register indices 4 and 5 return the error counts `err_cnt_i[15:0]` and `err_cnt_i[31:16]`, taken at the time of the access. Writes to these indices are ignored.
- R8: Register indices 6..15 read as zero. Writes to them have no effect on any register.
- R9: After reset, `ack_no_o` is high, `rdata_o` is zero, and all control registers, connection memory words and the read latch are zero.
- R10: Each strobe performs exactly one access, however long it is held. `rdata_o` is updated at the edge where the acknowledge asserts and stays stable while the acknowledge is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| ds_ni | input | 1 | Data strobe, active low |
| rw_i | input | 1 | 1 = read, 0 = write |
| addr_i | input | 14 | Host address |
| wdata_i | input | 16 | Host write data |
| rdata_o | output | 16 | Host read data, valid while acknowledged |
| ack_no_o | output | 1 | Data acknowledge, active low |
| err_cnt_i | input | 32 | Two 16-bit error counts supplied by the core |
| dm_we_i | input | 1 | Core write enable for data memory |
| dm_waddr_i | input | 6 | Core write index into data memory |
| dm_wdata_i | input | 16 | Core write data for data memory |

## Verification
The checks assume that the bus inputs are synchronous to `clk_i`. They also assume that address, read/write and write data stay stable from the start of a strobe until the acknowledge has been seen, and that a strobe ends with `ds_ni` going high before the next one begins. The stimulus changes inputs only at falling clock edges. Each task holds the address and data for the whole cycle, then releases chip select and strobe together. It also keeps one idle cycle between accesses, so every strobe starts from the idle state. Data memory is filled by the core only while the host bus is idle.

// File: rtl/mp_pkg.sv
`timescale 1ns/1ps
package mp_pkg;
  typedef enum logic [2:0] {RGN_CTRL, RGN_ERR, RGN_NONE, RGN_CM, RGN_DM} region_e;
  typedef enum logic [1:0] {BS_IDLE, BS_WAIT, BS_ACK} bus_state_e;
endpackage

// File: rtl/mp_bus_fsm.sv
`timescale 1ns/1ps
module mp_bus_fsm
  import mp_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic ds_ni,
  output logic acc_stb_o,
  output logic ack_no_o
);
  bus_state_e st_q, st_d;
  logic sel;

  assign sel = ~cs_ni & ~ds_ni;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      BS_IDLE: if (sel) st_d = BS_WAIT;
      BS_WAIT: st_d = sel ? BS_ACK : BS_IDLE;
      BS_ACK:  if (!sel) st_d = BS_IDLE;
      default: st_d = BS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= BS_IDLE;
    else         st_q <= st_d;
  end

  // single access per strobe, on the edge entering ACK
  assign acc_stb_o = (st_q == BS_WAIT) & sel;
  assign ack_no_o  = ~((st_q == BS_ACK) & sel);
endmodule

// File: rtl/mp_decode.sv
`timescale 1ns/1ps
module mp_decode
  import mp_pkg::*;
#(
  parameter int REG_AW    = 4,
  parameter int CTRL_REGS = 4,
  parameter int ERR_REGS  = 2
) (
  input  logic              dm_sel_i,
  input  logic              cm_sel_i,
  input  logic [REG_AW-1:0] idx_i,
  output region_e           region_o
);
  always_comb begin
    if (dm_sel_i)                              region_o = RGN_DM;
    else if (cm_sel_i)                         region_o = RGN_CM;
    else if (int'(idx_i) < CTRL_REGS)          region_o = RGN_CTRL;
    else if (int'(idx_i) < CTRL_REGS+ERR_REGS) region_o = RGN_ERR;
    else                                       region_o = RGN_NONE;
  end
endmodule

// File: rtl/mp_cfg_store.sv
`timescale 1ns/1ps
module mp_cfg_store #(
  parameter int DW        = 16,
  parameter int CTRL_REGS = 4,
  parameter int CM_WORDS  = 64,
  localparam int CTRL_SW  = (CTRL_REGS > 1) ? $clog2(CTRL_REGS) : 1,
  localparam int CM_AW    = (CM_WORDS > 1) ? $clog2(CM_WORDS) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ctrl_we_i,
  input  logic [CTRL_SW-1:0] ctrl_idx_i,
  input  logic               cm_we_i,
  input  logic [CM_AW-1:0]   cm_idx_i,
  input  logic [DW-1:0]      wdata_i,
  output logic [DW-1:0]      ctrl_rd_o,
  output logic [DW-1:0]      cm_rd_o
);
  logic [DW-1:0] ctrl_q [CTRL_REGS];
  logic [DW-1:0] cm_q   [CM_WORDS];

  for (genvar g = 0; g < CTRL_REGS; g++) begin : g_ctrl
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                         ctrl_q[g] <= '0;
      else if (ctrl_we_i && ctrl_idx_i == CTRL_SW'(g))     ctrl_q[g] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < CM_WORDS; i++) cm_q[i] <= '0;
    end else if (cm_we_i) begin
      cm_q[cm_idx_i] <= wdata_i;
    end
  end

  always_comb begin
    ctrl_rd_o = '0;
    for (int i = 0; i < CTRL_REGS; i++)
      if (ctrl_idx_i == CTRL_SW'(i)) ctrl_rd_o = ctrl_q[i];
  end

  assign cm_rd_o = cm_q[cm_idx_i];
endmodule

// File: rtl/mp_dm_port.sv
`timescale 1ns/1ps
module mp_dm_port #(
  parameter int DW       = 16,
  parameter int DM_WORDS = 64,
  localparam int DM_AW   = (DM_WORDS > 1) ? $clog2(DM_WORDS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             core_we_i,
  input  logic [DM_AW-1:0] core_idx_i,
  input  logic [DW-1:0]    core_wdata_i,
  input  logic             host_rd_i,
  input  logic [DM_AW-1:0] host_idx_i,
  output logic [DW-1:0]    latch_o
);
  logic [DW-1:0] mem_q [DM_WORDS];

  always_ff @(posedge clk_i) begin
    if (core_we_i) mem_q[core_idx_i] <= core_wdata_i;
  end

  // read latch: filled on one host read, returned on the next
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        latch_o <= '0;
    else if (host_rd_i) latch_o <= mem_q[host_idx_i];
  end
endmodule

// File: rtl/host_microport.sv
`timescale 1ns/1ps
module host_microport
  import mp_pkg::*;
#(
  parameter int AW        = 14,
  parameter int DW        = 16,
  parameter int REG_AW    = 4,
  parameter int CTRL_REGS = 4,
  parameter int ERR_REGS  = 2,
  parameter int CM_WORDS  = 64,
  parameter int DM_WORDS  = 64,
  localparam int DM_AW    = (DM_WORDS > 1) ? $clog2(DM_WORDS) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cs_ni,
  input  logic                   ds_ni,
  input  logic                   rw_i,
  input  logic [AW-1:0]          addr_i,
  input  logic [DW-1:0]          wdata_i,
  output logic [DW-1:0]          rdata_o,
  output logic                   ack_no_o,
  input  logic [ERR_REGS*DW-1:0] err_cnt_i,
  input  logic                   dm_we_i,
  input  logic [DM_AW-1:0]       dm_waddr_i,
  input  logic [DW-1:0]          dm_wdata_i
);
  localparam int CTRL_SW = (CTRL_REGS > 1) ? $clog2(CTRL_REGS) : 1;
  localparam int CM_AW   = (CM_WORDS > 1) ? $clog2(CM_WORDS) : 1;

  logic              acc_stb;
  region_e           region;
  logic [REG_AW-1:0] reg_idx;
  logic              dm_hit;
  logic              ctrl_we, cm_we, dm_rd;
  logic [DW-1:0]     ctrl_rd, cm_rd, dm_latch, err_rd, rd_mux;
  logic [DW-1:0]     err_arr [ERR_REGS];
  logic              unused_addr;

  assign unused_addr = ^addr_i;
  assign reg_idx     = addr_i[REG_AW-1:0];

  mp_bus_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cs_ni     (cs_ni),
    .ds_ni     (ds_ni),
    .acc_stb_o (acc_stb),
    .ack_no_o  (ack_no_o)
  );

  mp_decode #(
    .REG_AW    (REG_AW),
    .CTRL_REGS (CTRL_REGS),
    .ERR_REGS  (ERR_REGS)
  ) u_dec (
    .dm_sel_i (addr_i[AW-1]),
    .cm_sel_i (addr_i[AW-2]),
    .idx_i    (reg_idx),
    .region_o (region)
  );

  assign dm_hit  = (region == RGN_DM);
  assign ctrl_we = acc_stb & ~rw_i & (region == RGN_CTRL);
  assign cm_we   = acc_stb & ~rw_i & (region == RGN_CM);
  assign dm_rd   = acc_stb &  rw_i & dm_hit;

  mp_cfg_store #(
    .DW        (DW),
    .CTRL_REGS (CTRL_REGS),
    .CM_WORDS  (CM_WORDS)
  ) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ctrl_we_i  (ctrl_we),
    .ctrl_idx_i (reg_idx[CTRL_SW-1:0]),
    .cm_we_i    (cm_we),
    .cm_idx_i   (addr_i[CM_AW-1:0]),
    .wdata_i    (wdata_i),
    .ctrl_rd_o  (ctrl_rd),
    .cm_rd_o    (cm_rd)
  );

  mp_dm_port #(
    .DW       (DW),
    .DM_WORDS (DM_WORDS)
  ) u_dm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .core_we_i    (dm_we_i),
    .core_idx_i   (dm_waddr_i),
    .core_wdata_i (dm_wdata_i),
    .host_rd_i    (dm_rd),
    .host_idx_i   (addr_i[DM_AW-1:0]),
    .latch_o      (dm_latch)
  );

  for (genvar e = 0; e < ERR_REGS; e++) begin : g_err
    assign err_arr[e] = err_cnt_i[e*DW +: DW];
  end

  always_comb begin
    err_rd = '0;
    for (int e = 0; e < ERR_REGS; e++)
      if (int'(reg_idx) == CTRL_REGS + e) err_rd = err_arr[e];
  end

  always_comb begin
    unique case (region)
      RGN_CTRL: rd_mux = ctrl_rd;
      RGN_ERR:  rd_mux = err_rd;
      RGN_CM:   rd_mux = cm_rd;
      RGN_DM:   rd_mux = dm_latch;  // value latched by the previous read
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             rdata_o <= '0;
    else if (acc_stb & rw_i) rdata_o <= rd_mux;
  end
endmodule

// File: rtl/mp_checker.sv
`timescale 1ns/1ps
module mp_checker #(
  parameter int DW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cs_ni,
  input logic          ds_ni,
  input logic          rw_i,
  input logic          ack_no_o,
  input logic [DW-1:0] rdata_o,
  input logic          acc_stb,
  input logic          dm_hit,
  input logic [DW-1:0] dm_latch
);
  p_ack_delay_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_no_o |-> ($past(!cs_ni && !ds_ni, 1) && $past(!cs_ni && !ds_ni, 2)));

  p_ack_release_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ds_ni |=> ack_no_o);

  p_one_access_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_stb |=> !acc_stb);

  p_rdata_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ack_no_o && $past(!ack_no_o)) |-> $stable(rdata_o));

  p_dm_write_ignored_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_stb && !rw_i && dm_hit) |=> $stable(dm_latch));
endmodule

bind host_microport mp_checker #(.DW(DW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cs_ni    (cs_ni),
  .ds_ni    (ds_ni),
  .rw_i     (rw_i),
  .ack_no_o (ack_no_o),
  .rdata_o  (rdata_o),
  .acc_stb  (acc_stb),
  .dm_hit   (dm_hit),
  .dm_latch (dm_latch)
);

// File: tb/sim_host_microport.sv
`timescale 1ns/1ps
module sim_host_microport;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cs_ni = 1'b1, ds_ni = 1'b1, rw_i = 1'b1;
  logic [13:0] addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        ack_no_o;
  logic [31:0] err_cnt_i = {16'h1234, 16'h0BAD};
  logic        dm_we_i = 1'b0;
  logic [5:0]  dm_waddr_i = '0;
  logic [15:0] dm_wdata_i = '0;

  int n_chk = 0, n_fail = 0;
  logic [15:0] exp_latch = '0;
  logic [15:0] rd, rd2;

  always #2.5 clk = ~clk;

  host_microport u0 (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_ni), .ds_ni(ds_ni), .rw_i(rw_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .ack_no_o(ack_no_o),
    .err_cnt_i(err_cnt_i), .dm_we_i(dm_we_i), .dm_waddr_i(dm_waddr_i),
    .dm_wdata_i(dm_wdata_i)
  );

  function automatic logic [15:0] cm_pat(int i);
    return 16'((i * 16'h0421) ^ 16'hBEEF);
  endfunction
  function automatic logic [15:0] dm_pat(int i);
    return 16'(i * 16'h0103 + 16'h7000);
  endfunction
  function automatic logic [15:0] ctrl_pat(int i);
    return 16'(16'h1357 * (i + 1));
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus(input logic rw, input logic [13:0] a, input logic [15:0] wd,
                     input int hold, output logic [15:0] r);
    int n = 0;
    @(negedge clk);
    addr_i = a; rw_i = rw; wdata_i = wd; cs_ni = 1'b0; ds_ni = 1'b0;
    while (ack_no_o && n < 8) begin
      @(negedge clk);
      n++;
    end
    chk("R1 ack latency", 16'(n), 16'd2);
    repeat (hold) @(negedge clk);
    r = rdata_o;
    ds_ni = 1'b1; cs_ni = 1'b1;
    #1 chk("R2 ack release", 16'(ack_no_o), 16'd1);
    @(negedge clk);
  endtask

  task automatic core_wr(input int i, input logic [15:0] d);
    @(negedge clk);
    dm_we_i = 1'b1; dm_waddr_i = 6'(i); dm_wdata_i = d;
    @(negedge clk);
    dm_we_i = 1'b0;
  endtask

  function automatic logic [13:0] a_ctrl(int i); return 14'(i);           endfunction
  function automatic logic [13:0] a_cm(int i);   return 14'h1000 | 14'(i); endfunction
  function automatic logic [13:0] a_dm(int i);   return 14'h2000 | 14'(i); endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset ack", 16'(ack_no_o), 16'd1);
    chk("R9 reset rdata", rdata_o, 16'h0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R9: zero contents after reset
    for (int i = 0; i < 4; i++) begin
      bus(1'b1, a_ctrl(i), '0, 0, rd); chk("R9 ctrl reset", rd, 16'h0);
    end
    for (int i = 0; i < 64; i++) begin
      bus(1'b1, a_cm(i), '0, 0, rd); chk("R9 cm reset", rd, 16'h0);
    end

    // R3: control registers
    for (int i = 0; i < 4; i++) bus(1'b0, a_ctrl(i), ctrl_pat(i), 0, rd);
    for (int i = 0; i < 4; i++) begin
      bus(1'b1, a_ctrl(i), '0, 0, rd); chk("R3 ctrl readback", rd, ctrl_pat(i));
    end

    // R4: connection memory
    for (int i = 0; i < 64; i++) bus(1'b0, a_cm(i), cm_pat(i), 0, rd);
    for (int i = 63; i >= 0; i--) begin
      bus(1'b1, a_cm(i), '0, 0, rd); chk("R4 cm readback", rd, cm_pat(i));
    end

    // R5: fill data memory, then sweep single reads (each returns previous word)
    for (int i = 0; i < 64; i++) core_wr(i, dm_pat(i));
    bus(1'b1, a_dm(5), '0, 0, rd); chk("R9 latch reset", rd, 16'h0);
    exp_latch = dm_pat(5);
    for (int i = 0; i < 64; i++) begin
      bus(1'b1, a_dm(i), '0, 0, rd); chk("R5 stale read", rd, exp_latch);
      exp_latch = dm_pat(i);
    end
    for (int i = 0; i < 64; i += 3) begin
      bus(1'b1, a_dm(i), '0, 0, rd);
      bus(1'b1, a_dm(i), '0, 0, rd2); chk("R5 repeated read", rd2, dm_pat(i));
    end
    exp_latch = dm_pat(63);

    // R6: host write to data memory ignored
    bus(1'b0, a_dm(7), 16'h0000, 0, rd);
    bus(1'b1, a_dm(7), '0, 0, rd);  chk("R6 latch kept", rd, exp_latch);
    bus(1'b1, a_dm(7), '0, 0, rd);  chk("R6 word kept", rd, dm_pat(7));
    exp_latch = dm_pat(7);

    // R10: long strobe performs one access
    bus(1'b1, a_dm(9), '0, 6, rd);  chk("R10 single access", rd, exp_latch);
    bus(1'b1, a_dm(9), '0, 0, rd);  chk("R10 follow-up", rd, dm_pat(9));

    // R7: error count registers
    bus(1'b1, a_ctrl(4), '0, 0, rd); chk("R7 err0", rd, 16'h0BAD);
    bus(1'b1, a_ctrl(5), '0, 0, rd); chk("R7 err1", rd, 16'h1234);
    bus(1'b0, a_ctrl(4), 16'hFFFF, 0, rd);
    bus(1'b0, a_ctrl(5), 16'hFFFF, 0, rd);
    bus(1'b1, a_ctrl(4), '0, 0, rd); chk("R7 err0 after write", rd, 16'h0BAD);
    bus(1'b1, a_ctrl(5), '0, 0, rd); chk("R7 err1 after write", rd, 16'h1234);
    err_cnt_i = {16'h00A1, 16'h5A5A};
    bus(1'b1, a_ctrl(4), '0, 0, rd); chk("R7 err0 live", rd, 16'h5A5A);
    bus(1'b1, a_ctrl(5), '0, 0, rd); chk("R7 err1 live", rd, 16'h00A1);

    // R8: unmapped register slots
    for (int i = 6; i < 16; i++) begin
      bus(1'b0, a_ctrl(i), 16'hFFFF, 0, rd);
      bus(1'b1, a_ctrl(i), '0, 0, rd); chk("R8 unmapped zero", rd, 16'h0);
    end
    for (int i = 0; i < 4; i++) begin
      bus(1'b1, a_ctrl(i), '0, 0, rd); chk("R8 ctrl untouched", rd, ctrl_pat(i));
    end

    // R1: strobe without chip select
    @(negedge clk);
    addr_i = a_ctrl(0); rw_i = 1'b0; wdata_i = 16'hDEAD; cs_ni = 1'b1; ds_ni = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); chk("R1 no ack without cs", 16'(ack_no_o), 16'd1);
    end
    ds_ni = 1'b1;
    @(negedge clk);
    bus(1'b1, a_ctrl(0), '0, 0, rd); chk("R1 no write without cs", rd, ctrl_pat(0));

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule